// File: doc/BRIEF.md
# Register Bit-Field Unit

This combinational unit operates on a bit field of variable position and size inside a 32-bit register value. The caller supplies an operation code, the register value, a field offset, a field width and, for inserts, a source value. The unit returns the rewritten register value, a result word for extracts and searches, and the N, Z, V and C condition flags.

The offset is counted from the most significant bit toward bit 0. A field that runs past bit 0 continues at bit 31. The offset and width inputs are full register values and are reduced modulo 32. A reduced width of zero selects a 32-bit field. The eight operations fall into three groups:

- Four that test a field and then rewrite it.
- One that inserts a source value into the field.
- Three that only read the field: two extracts and a leading-one search.

Top module: `bitfield_unit`

## Requirements
- R1: Bits are numbered 31 (MSB) down to 0. The field starts at bit position 31-(ofs_i mod 32) and runs toward lower bit numbers. After bit 0 it wraps to bit 31. Bits 31..5 of ofs_i are ignored.
- R2: The field width is wid_i mod 32, and a value of 0 selects all 32 bits. Bits 31..5 of wid_i are ignored.
- R3: Operation code 0 (test) returns res_o equal to tgt_i.
- R4: Operation codes 1 (set), 2 (clear) and 3 (change) drive the field bits of res_o to ones, to zeros, or to the inverse of the field bits, respectively. Every bit outside the field equals tgt_i.
- R5: For operation codes 0, 1, 2, 3, 5, 6 and 7, n_o equals the most significant field bit of tgt_i before modification, and z_o is 1 exactly when every field bit of tgt_i is 0.
- R6: Operation code 4 (insert) writes the low width bits of src_i into the field, with src_i bit (width-1) landing on the field's most significant bit. Bits outside the field are kept. n_o is src_i bit (width-1), and z_o is 1 when those low width bits are all 0.
- R7: Operation code 5 (signed extract) returns in val_o the field right-aligned and sign-extended to 32 bits.
- R8: Operation code 6 (unsigned extract) returns in val_o the field right-aligned and zero-extended.
- R9: Operation code 7 (find first one) scans the field from its most significant end. It returns (ofs_i mod 32) plus the index of the first one bit, where index 0 is the field's most significant bit. If the field holds no one bit, it returns (ofs_i mod 32) plus the width.
- R10: v_o and c_o are always 0. val_o is 0 for operation codes 0 to 4. res_o equals tgt_i for operation codes 5 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code, 0 to 7 |
| tgt_i | input | 32 | Register value holding the field |
| ofs_i | input | 32 | Field offset from the MSB, taken modulo 32 |
| wid_i | input | 32 | Field width, taken modulo 32, 0 meaning 32 |
| src_i | input | 32 | Source value for the insert operation |
| res_o | output | 32 | Register value after the operation |
| val_o | output | 32 | Extracted field or search result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag, always 0 |
| c_o | output | 1 | Carry flag, always 0 |

## Verification
The bench sweeps every offset and width pair for every operation. Each sweep runs over several register and source patterns, and the offsets carry random upper bits. This reaches the fields that wrap past bit 0, the 32-bit field encoded as width zero, and the one-bit fields at either end.

A design with the rotation direction wrong, or that counts the offset from bit 0, would corrupt bits next to the field and give wrong N flags. A design that treats width zero as empty would return zero on full-word extracts and leave full-word sets untouched. A search that gives up early, or that reports the raw width on an empty field, would be off by the offset or by the wrap. Sign extension that slips by one bit would show up on negative fields just below full width.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

  typedef enum logic [2:0] {
    BF_TST  = 3'd0,
    BF_SET  = 3'd1,
    BF_CLR  = 3'd2,
    BF_CHG  = 3'd3,
    BF_INS  = 3'd4,
    BF_EXTS = 3'd5,
    BF_EXTU = 3'd6,
    BF_FFO  = 3'd7
  } bf_op_e;

  typedef struct packed {
    logic n;
    logic z;
  } bf_flags_t;

endpackage

// File: rtl/bf_locate.sv
// Turns offset/width into a field mask and an MSB-aligned view of the target.
module bf_locate #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] tgt,
  input  logic [IDX_W-1:0]  ofs,
  input  logic [IDX_W-1:0]  wid,
  output logic [DATA_W-1:0] rot,
  output logic [DATA_W-1:0] mask_rot,
  output logic [DATA_W-1:0] mask,
  output logic [IDX_W-1:0]  sh,
  output logic [IDX_W:0]    wfull,
  output logic [DATA_W-1:0] fld_u,
  output logic              fld_msb,
  output logic              fld_zero
);

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] v,
                                              input logic [IDX_W-1:0] n);
    logic [2*DATA_W-1:0] d;
    d = {v, v} << n;
    return d[2*DATA_W-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] rotr(input logic [DATA_W-1:0] v,
                                              input logic [IDX_W-1:0] n);
    logic [2*DATA_W-1:0] d;
    d = {v, v} >> n;
    return d[DATA_W-1:0];
  endfunction

  // Field MSB moves to bit DATA_W-1 after a left rotate by the offset.
  assign rot      = rotl(tgt, ofs);
  // Shift that right-aligns a field of wfull bits: (DATA_W - wfull) mod DATA_W.
  assign sh       = IDX_W'(0) - wid;
  assign wfull    = (wid == '0) ? (IDX_W+1)'(DATA_W) : {1'b0, wid};
  assign mask_rot = {DATA_W{1'b1}} << sh;
  assign mask     = rotr(mask_rot, ofs);
  assign fld_u    = rot >> sh;
  assign fld_msb  = rot[DATA_W-1];
  assign fld_zero = ((rot & mask_rot) == '0);

endmodule

// File: rtl/bf_modify.sv
// Builds the rewritten target for set/clear/change/insert.
module bf_modify
  import bitfield_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  bf_op_e            op,
  input  logic [DATA_W-1:0] tgt,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] src,
  input  logic [IDX_W-1:0]  ofs,
  input  logic [IDX_W-1:0]  sh,
  output logic [DATA_W-1:0] res,
  output logic              ins_msb,
  output logic              ins_zero
);

  function automatic logic [DATA_W-1:0] rotr(input logic [DATA_W-1:0] v,
                                              input logic [IDX_W-1:0] n);
    logic [2*DATA_W-1:0] d;
    d = {v, v} >> n;
    return d[DATA_W-1:0];
  endfunction

  logic [DATA_W-1:0] src_top;
  logic [DATA_W-1:0] ins_place;

  // Low field-width bits of src moved to the top, then rotated into place.
  assign src_top   = src << sh;
  assign ins_place = rotr(src_top, ofs);
  assign ins_msb   = src_top[DATA_W-1];
  assign ins_zero  = (src_top == '0);

  always_comb begin
    unique case (op)
      BF_SET:  res = tgt | mask;
      BF_CLR:  res = tgt & ~mask;
      BF_CHG:  res = tgt ^ mask;
      BF_INS:  res = (tgt & ~mask) | ins_place;
      default: res = tgt;
    endcase
  end

endmodule

// File: rtl/bf_ffo.sv
// Leading-one search inside the MSB-aligned field.
module bf_ffo #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] fld_top,
  input  logic [IDX_W:0]    wfull,
  input  logic [IDX_W-1:0]  ofs,
  output logic              found,
  output logic [IDX_W:0]    pos,
  output logic [DATA_W-1:0] ffo_val
);

  function automatic logic [IDX_W:0] lead_zeros(input logic [DATA_W-1:0] v);
    logic [IDX_W:0] n;
    logic           hit;
    n   = (IDX_W+1)'(DATA_W);
    hit = 1'b0;
    for (int i = DATA_W-1; i >= 0; i--) begin
      if (!hit && v[i]) begin
        hit = 1'b1;
        n   = (IDX_W+1)'(DATA_W-1-i);
      end
    end
    return n;
  endfunction

  logic [IDX_W:0] lz;

  assign lz      = lead_zeros(fld_top);
  assign found   = (fld_top != '0);
  assign pos     = found ? lz : wfull;
  assign ffo_val = DATA_W'(ofs) + DATA_W'(pos);

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bitfield_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] tgt_i,
  input  logic [DATA_W-1:0] ofs_i,
  input  logic [DATA_W-1:0] wid_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] val_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o
);

  localparam int IDX_W = $clog2(DATA_W);

  bf_op_e            op_w;
  logic [IDX_W-1:0]  ofs_w;
  logic [IDX_W-1:0]  wid_w;
  logic [DATA_W-1:0] rot_w;
  logic [DATA_W-1:0] mask_rot_w;
  logic [DATA_W-1:0] mask_w;
  logic [IDX_W-1:0]  sh_w;
  logic [IDX_W:0]    wfull_w;
  logic [DATA_W-1:0] fld_u_w;
  logic [DATA_W-1:0] fld_s_w;
  logic              fld_msb_w;
  logic              fld_zero_w;
  logic              ins_msb_w;
  logic              ins_zero_w;
  logic              ffo_found_w;
  logic [IDX_W:0]    ffo_pos_w;
  logic [DATA_W-1:0] ffo_val_w;
  bf_flags_t         flags_w;
  logic              unused_hi;

  assign op_w      = bf_op_e'(op_i);
  assign ofs_w     = ofs_i[IDX_W-1:0];
  assign wid_w     = wid_i[IDX_W-1:0];
  assign unused_hi = ^{ofs_i[DATA_W-1:IDX_W], wid_i[DATA_W-1:IDX_W]};

  bf_locate #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_loc (
    .tgt      (tgt_i),
    .ofs      (ofs_w),
    .wid      (wid_w),
    .rot      (rot_w),
    .mask_rot (mask_rot_w),
    .mask     (mask_w),
    .sh       (sh_w),
    .wfull    (wfull_w),
    .fld_u    (fld_u_w),
    .fld_msb  (fld_msb_w),
    .fld_zero (fld_zero_w)
  );

  bf_modify #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mod (
    .op       (op_w),
    .tgt      (tgt_i),
    .mask     (mask_w),
    .src      (src_i),
    .ofs      (ofs_w),
    .sh       (sh_w),
    .res      (res_o),
    .ins_msb  (ins_msb_w),
    .ins_zero (ins_zero_w)
  );

  bf_ffo #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ffo (
    .fld_top (rot_w & mask_rot_w),
    .wfull   (wfull_w),
    .ofs     (ofs_w),
    .found   (ffo_found_w),
    .pos     (ffo_pos_w),
    .ffo_val (ffo_val_w)
  );

  // Arithmetic right shift of the aligned field gives the sign extension.
  assign fld_s_w = DATA_W'($signed(rot_w) >>> sh_w);

  always_comb begin
    unique case (op_w)
      BF_EXTS: val_o = fld_s_w;
      BF_EXTU: val_o = fld_u_w;
      BF_FFO:  val_o = ffo_val_w;
      default: val_o = '0;
    endcase
  end

  always_comb begin
    if (op_w == BF_INS) begin
      flags_w.n = ins_msb_w;
      flags_w.z = ins_zero_w;
    end else begin
      flags_w.n = fld_msb_w;
      flags_w.z = fld_zero_w;
    end
  end

  assign n_o = flags_w.n;
  assign z_o = flags_w.z;
  assign v_o = 1'b0;
  assign c_o = 1'b0;

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] tgt_i,
  input logic [DATA_W-1:0] res_o,
  input logic [DATA_W-1:0] val_o,
  input logic              z_o,
  input logic [DATA_W-1:0] mask_w,
  input logic [IDX_W:0]    wfull_w,
  input logic [IDX_W-1:0]  ofs_w,
  input logic              ffo_found_w
);

  always_comb begin
    AST_MASK_WIDTH: assert ($countones(mask_w) == int'(wfull_w)) else $error("mask width"); // R2
    AST_OUTSIDE_KEPT: assert (((res_o ^ tgt_i) & ~mask_w) == '0) else $error("outside bits"); // R4
    if (op_i == 3'd0 || op_i >= 3'd5)
      AST_READ_ONLY: assert (res_o == tgt_i) else $error("read op wrote"); // R10
    if (op_i == 3'd1)
      AST_SET_FILLS: assert ((res_o & mask_w) == mask_w) else $error("set"); // R4
    if (op_i == 3'd6)
      AST_EXTU_Z: assert (z_o == (val_o == '0)) else $error("extu z"); // R8
    if (op_i == 3'd7 && !ffo_found_w)
      AST_FFO_EMPTY: assert (val_o == DATA_W'(ofs_w) + DATA_W'(wfull_w)) else $error("ffo empty"); // R9
    if (op_i == 3'd7)
      AST_FFO_RANGE: assert (val_o >= DATA_W'(ofs_w) && val_o <= DATA_W'(ofs_w) + DATA_W'(wfull_w))
        else $error("ffo range"); // R9
  end

endmodule

bind bitfield_unit bitfield_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i        (op_i),
  .tgt_i       (tgt_i),
  .res_o       (res_o),
  .val_o       (val_o),
  .z_o         (z_o),
  .mask_w      (mask_w),
  .wfull_w     (wfull_w),
  .ofs_w       (ofs_w),
  .ffo_found_w (ffo_found_w)
);

// File: tb/sim_bitfield_unit.sv
`timescale 1ns/1ps
module sim_bitfield_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op;
  logic [31:0] tgt, ofs, wid, src;
  logic [31:0] res, val;
  logic        n, z, v, c;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  bitfield_unit u0 (
    .op_i(op), .tgt_i(tgt), .ofs_i(ofs), .wid_i(wid), .src_i(src),
    .res_o(res), .val_o(val), .n_o(n), .z_o(z), .v_o(v), .c_o(c)
  );

  function automatic string req_of(int o);
    case (o)
      0: return "R3";
      1, 2, 3: return "R4";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s op=%0d ofs=%0d wid=%0d tgt=%h: actual %h expected %h",
               tag, what, op, ofs, wid, tgt, act, exp);
    end
  endtask

  // Bit-serial model: field bit i (i=0 is the field MSB) sits at (31-o-i) mod 32 (R1).
  task automatic run_one(int o_op, logic [31:0] t, int o, int w, logic [31:0] s, int hi);
    int wf, p, pos;
    logic [31:0] fv, er, ev, iv;
    logic en, ez;
    wf = (w == 0) ? 32 : w;                 // R2
    fv = '0; er = t; pos = wf; iv = '0;
    for (int i = 0; i < wf; i++) begin
      p  = (95 - o - i) % 32;
      fv = (fv << 1) | 32'(t[p]);
      if (pos == wf && t[p]) pos = i;
      case (o_op)
        1: er[p] = 1'b1;
        2: er[p] = 1'b0;
        3: er[p] = ~t[p];
        4: er[p] = s[wf-1-i];
        default: ;
      endcase
    end
    for (int i = 0; i < wf; i++) iv[i] = s[i];
    en = t[(95 - o) % 32];                  // R5
    ez = (fv == 0);
    ev = '0;                                 // R10 for codes 0..4
    case (o_op)
      4: begin en = s[wf-1]; ez = (iv == 0); end
      5: ev = (en && wf < 32) ? (fv | (32'hFFFF_FFFF << wf)) : fv;
      6: ev = fv;
      7: ev = 32'(o + pos);
      default: ;
    endcase
    @(posedge clk);
    op  = 3'(o_op);
    tgt = t;
    ofs = {27'(hi), 5'(o)};
    wid = {27'(hi * 7 + 3), 5'(w)};
    src = s;
    @(negedge clk);
    chk(req_of(o_op), "res", res, er);
    chk(req_of(o_op), "val", val, ev);
    chk(o_op == 4 ? "R6" : "R5", "flags", {30'd0, n, z}, {30'd0, en, ez});
    chk("R10", "vc", {30'd0, v, c}, 32'd0);
  endtask

  initial begin
    logic [31:0] tpat [4];
    logic [31:0] spat [4];
    tpat[0] = 32'h0000_0000; tpat[1] = 32'hFFFF_FFFF;
    tpat[2] = 32'h8000_0001; tpat[3] = 32'hA5C3_1E96;
    spat[0] = 32'hFFFF_FFFF; spat[1] = 32'h0000_0000;
    spat[2] = 32'h1234_5679; spat[3] = 32'h8000_0000;
    op = '0; tgt = '0; ofs = '0; wid = '0; src = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle inputs: full-word test of zero (R3, R5).
    chk("R3", "idle res", res, 32'd0);
    chk("R5", "idle flags", {30'd0, n, z}, 32'd1);
    for (int k = 0; k < 8; k++)
      for (int pt = 0; pt < 4; pt++)
        for (int o = 0; o < 32; o++)
          for (int w = 0; w < 32; w++)
            run_one(k, tpat[pt] ^ (32'(o * w) << 3), o, w, spat[pt] ^ 32'(w << 9),
                    (pt * 1021 + o * 37 + w) & 32'h7FF_FFFF);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule